// File: doc/BRIEF.md
# Vertical Linear-Probe Hash Lookup Engine

This block looks up a stream of keys in a small on-chip open-addressing hash table that resolves collisions by linear probing. It keeps several lanes, and each lane owns one key in flight together with that key's current slot. The lanes move through the table independently. A lane that finds its key, reaches an empty slot, or has visited every slot reports one result and takes a fresh key at once. A lane that does not match moves to the next slot. This keeps every lane busy even when the probe chains have very different lengths.

The table holds a key and a payload in each slot. It is filled through a write port while the engine has nothing in flight. One read port serves the lanes in turn, so a round visits each lane once in lane-index order. Keys arrive on a valid/ready stream. Results leave one per cycle on a valid/ready stream that carries the hit flag, the key, the slot where the search ended and the payload. When the input stream stops, the busy lanes drain and go idle.

Top module: `hash_probe_engine`

## Requirements
- R1: After reset, `res_valid_o` is 0, `idle_o` is 1 and `key_ready_o` is 1, and every table slot holds the empty marker (key all ones, payload 0).
- R2: A write with `wr_en_i` high stores `wr_key_i` and `wr_pay_i` at slot `wr_addr_i`. A later lookup of a key stored at its home slot returns hit=1, that slot and that payload.
- R3: A key's home slot is the XOR of all `ADDR_W`-bit chunks of the key, with the lowest chunk starting at bit 0. For 8-bit keys and 16 slots this is key[3:0] ^ key[7:4]. Every search starts at the home slot.
- R4: When a compare fails, the lane compares at the next slot on its next visit, wrapping from slot 2^ADDR_W-1 to slot 0. A key stored away from its home slot is found with the slot where it is stored.
- R5: Reaching a slot whose stored key is all ones ends the search with hit=0, that slot reported, and payload 0.
- R6: If 2^ADDR_W compares find neither the key nor an empty slot, the search ends with hit=0, slot (home-1) mod 2^ADDR_W, and payload 0.
- R7: While `res_valid_o` is 1 and `res_ready_i` is 0, all result outputs hold their values. Each accepted key produces exactly one result.
- R8: A lane is refilled as soon as its own search ends. A key with a short search is reported before an earlier key whose search is longer. When every key hits at its home slot, results leave in the order the keys were accepted.
- R9: A lane that ends its search takes the next key in the same cycle. With keys hitting at home and `res_ready_i` held at 1, a key is accepted on every cycle. `key_ready_o` is 0 while the result output is stalled.
- R10: `idle_o` is 0 while any accepted key has not yet been delivered. Once the input stops and the last result is taken, `idle_o` rises on the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Table write strobe |
| wr_addr_i | input | ADDR_W | Slot to write |
| wr_key_i | input | KEY_W | Key to store (all ones marks the slot empty) |
| wr_pay_i | input | PAY_W | Payload to store |
| key_valid_i | input | 1 | Lookup key offered |
| key_i | input | KEY_W | Lookup key (never all ones) |
| key_ready_o | output | 1 | Key accepted this cycle when valid is also high |
| res_valid_o | output | 1 | Result present |
| res_ready_i | input | 1 | Result taken this cycle when valid is also high |
| res_hit_o | output | 1 | 1 when the key was found |
| res_key_o | output | KEY_W | Key the result belongs to |
| res_slot_o | output | ADDR_W | Slot where the search ended |
| res_pay_o | output | PAY_W | Stored payload on a hit, 0 on a miss |
| idle_o | output | 1 | No key in flight and no result pending |

## Verification
Two events can share a cycle: a lane ending its search, and that same lane taking the next input key. The bench provokes this by streaming keys that all hit at their home slots with the output always ready. It then requires that keys are accepted on consecutive cycles and that results come back in acceptance order. It also lets a result stall against a ready that toggles in a pattern, while a lane is due to finish. In that case no key may be taken, and the stalled result must stay frozen. Every key value except the empty marker is swept through an empty table, a sparse table with a wrapped chain, and a full table. Each result is compared with a slot walk that the bench computes on its own.

// File: rtl/hp_pkg.sv
package hp_pkg;
  // outcome of comparing the visited lane against its slot
  typedef enum logic [2:0] {
    PR_IDLE,
    PR_CONT,
    PR_HIT,
    PR_EMPTY,
    PR_LAPPED
  } probe_res_e;

  typedef enum logic [1:0] {
    LOP_HOLD,
    LOP_LOAD,
    LOP_STEP,
    LOP_FREE
  } lane_op_e;
endpackage

// File: rtl/hp_hash.sv
module hp_hash #(
  parameter int KEY_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic [KEY_W-1:0]  key_i,
  output logic [ADDR_W-1:0] idx_o
);
  localparam int NCH = (KEY_W + ADDR_W - 1) / ADDR_W;

  logic [NCH*ADDR_W-1:0] padded;
  assign padded = (NCH*ADDR_W)'(key_i);

  always_comb begin
    idx_o = '0;
    for (int c = 0; c < NCH; c++) idx_o = idx_o ^ padded[c*ADDR_W +: ADDR_W];
  end
endmodule

// File: rtl/hp_table.sv
module hp_table #(
  parameter int KEY_W  = 8,
  parameter int PAY_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [PAY_W-1:0]  wr_pay_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [KEY_W-1:0]  rd_key_o,
  output logic [PAY_W-1:0]  rd_pay_o
);
  localparam int SLOTS = 1 << ADDR_W;

  logic [KEY_W-1:0] key_v [SLOTS];
  logic [PAY_W-1:0] pay_v [SLOTS];

  for (genvar s = 0; s < SLOTS; s++) begin : slot_g
    logic [KEY_W-1:0] key_q;
    logic [PAY_W-1:0] pay_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        key_q <= '1;
        pay_q <= '0;
      end else if (wr_en_i && wr_addr_i == ADDR_W'(s)) begin
        key_q <= wr_key_i;
        pay_q <= wr_pay_i;
      end
    end
    assign key_v[s] = key_q;
    assign pay_v[s] = pay_q;
  end

  assign rd_key_o = key_v[rd_addr_i];
  assign rd_pay_o = pay_v[rd_addr_i];
endmodule

// File: rtl/hp_lanes.sv
module hp_lanes #(
  parameter int LANES  = 4,
  parameter int KEY_W  = 8,
  parameter int ADDR_W = 4,
  parameter int LANE_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [LANE_W-1:0] sel_i,
  input  hp_pkg::lane_op_e  op_i,
  input  logic [KEY_W-1:0]  new_key_i,
  input  logic [ADDR_W-1:0] new_slot_i,
  output logic              cur_act_o,
  output logic [KEY_W-1:0]  cur_key_o,
  output logic [ADDR_W-1:0] cur_slot_o,
  output logic [ADDR_W-1:0] cur_cnt_o,
  output logic              any_act_o
);
  import hp_pkg::*;

  logic [LANES-1:0] act_v;
  logic [KEY_W-1:0]  key_v  [LANES];
  logic [ADDR_W-1:0] slot_v [LANES];
  logic [ADDR_W-1:0] cnt_v  [LANES];

  for (genvar l = 0; l < LANES; l++) begin : lane_g
    logic              act_q;
    logic [KEY_W-1:0]  key_q;
    logic [ADDR_W-1:0] slot_q;
    logic [ADDR_W-1:0] cnt_q;  // compares already made for this key
    logic              mine;
    assign mine = (sel_i == LANE_W'(l));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        act_q  <= 1'b0;
        key_q  <= '0;
        slot_q <= '0;
        cnt_q  <= '0;
      end else if (mine) begin
        case (op_i)
          LOP_LOAD: begin
            act_q  <= 1'b1;
            key_q  <= new_key_i;
            slot_q <= new_slot_i;
            cnt_q  <= '0;
          end
          LOP_STEP: begin
            slot_q <= slot_q + 1'b1;  // wraps at table end
            cnt_q  <= cnt_q + 1'b1;
          end
          LOP_FREE: act_q <= 1'b0;
          default: ;
        endcase
      end
    end

    assign act_v[l]  = act_q;
    assign key_v[l]  = key_q;
    assign slot_v[l] = slot_q;
    assign cnt_v[l]  = cnt_q;
  end

  assign cur_act_o  = act_v[sel_i];
  assign cur_key_o  = key_v[sel_i];
  assign cur_slot_o = slot_v[sel_i];
  assign cur_cnt_o  = cnt_v[sel_i];
  assign any_act_o  = |act_v;
endmodule

// File: rtl/hash_probe_engine.sv
module hash_probe_engine #(
  parameter int LANES  = 4,
  parameter int KEY_W  = 8,
  parameter int PAY_W  = 8,
  parameter int ADDR_W = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [KEY_W-1:0]  wr_key_i,
  input  logic [PAY_W-1:0]  wr_pay_i,
  input  logic              key_valid_i,
  input  logic [KEY_W-1:0]  key_i,
  output logic              key_ready_o,
  output logic              res_valid_o,
  input  logic              res_ready_i,
  output logic              res_hit_o,
  output logic [KEY_W-1:0]  res_key_o,
  output logic [ADDR_W-1:0] res_slot_o,
  output logic [PAY_W-1:0]  res_pay_o,
  output logic              idle_o
);
  import hp_pkg::*;

  localparam int SLOTS  = 1 << ADDR_W;
  localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [KEY_W-1:0] EMPTY_KEY = '1;

  logic [LANE_W-1:0] ptr_q;
  logic              stall, fin, take;
  probe_res_e        kind;
  lane_op_e          lop;

  logic              cur_act, any_act;
  logic [KEY_W-1:0]  cur_key, rd_key;
  logic [ADDR_W-1:0] cur_slot, cur_cnt, home_idx;
  logic [PAY_W-1:0]  rd_pay;

  logic              rv_q, rhit_q;
  logic [KEY_W-1:0]  rkey_q;
  logic [ADDR_W-1:0] rslot_q;
  logic [PAY_W-1:0]  rpay_q;

  hp_hash #(.KEY_W(KEY_W), .ADDR_W(ADDR_W)) u_hash (
    .key_i (key_i),
    .idx_o (home_idx)
  );

  hp_table #(.KEY_W(KEY_W), .PAY_W(PAY_W), .ADDR_W(ADDR_W)) u_table (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_key_i  (wr_key_i),
    .wr_pay_i  (wr_pay_i),
    .rd_addr_i (cur_slot),
    .rd_key_o  (rd_key),
    .rd_pay_o  (rd_pay)
  );

  hp_lanes #(.LANES(LANES), .KEY_W(KEY_W), .ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_lanes (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sel_i      (ptr_q),
    .op_i       (lop),
    .new_key_i  (key_i),
    .new_slot_i (home_idx),
    .cur_act_o  (cur_act),
    .cur_key_o  (cur_key),
    .cur_slot_o (cur_slot),
    .cur_cnt_o  (cur_cnt),
    .any_act_o  (any_act)
  );

  assign stall = rv_q && !res_ready_i;

  always_comb begin
    if (!cur_act)                          kind = PR_IDLE;
    else if (rd_key == cur_key)            kind = PR_HIT;
    else if (rd_key == EMPTY_KEY)          kind = PR_EMPTY;
    else if (cur_cnt == ADDR_W'(SLOTS-1))  kind = PR_LAPPED;
    else                                   kind = PR_CONT;
  end

  assign fin         = (kind == PR_HIT) || (kind == PR_EMPTY) || (kind == PR_LAPPED);
  assign key_ready_o = !stall && (!cur_act || fin);
  assign take        = key_ready_o && key_valid_i;

  always_comb begin
    lop = LOP_HOLD;
    if (!stall) begin
      if (take)                 lop = LOP_LOAD;
      else if (fin)             lop = LOP_FREE;
      else if (kind == PR_CONT) lop = LOP_STEP;
    end
  end

  // lane visit pointer: one lane per cycle, frozen while the output is stalled
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else if (!stall) begin
      if (ptr_q == LANE_W'(LANES-1)) ptr_q <= '0;
      else                           ptr_q <= ptr_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rv_q    <= 1'b0;
      rhit_q  <= 1'b0;
      rkey_q  <= '0;
      rslot_q <= '0;
      rpay_q  <= '0;
    end else if (!stall) begin
      rv_q <= fin;
      if (fin) begin
        rhit_q  <= (kind == PR_HIT);
        rkey_q  <= cur_key;
        rslot_q <= cur_slot;
        rpay_q  <= (kind == PR_HIT) ? rd_pay : '0;
      end
    end
  end

  assign res_valid_o = rv_q;
  assign res_hit_o   = rhit_q;
  assign res_key_o   = rkey_q;
  assign res_slot_o  = rslot_q;
  assign res_pay_o   = rpay_q;
  assign idle_o      = !any_act && !rv_q;
endmodule

// File: rtl/hash_probe_engine_chk.sv
module hash_probe_engine_chk #(
  parameter int KEY_W  = 8,
  parameter int PAY_W  = 8,
  parameter int ADDR_W = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              key_valid_i,
  input logic              key_ready_o,
  input logic              res_valid_o,
  input logic              res_ready_i,
  input logic              res_hit_o,
  input logic [KEY_W-1:0]  res_key_o,
  input logic [ADDR_W-1:0] res_slot_o,
  input logic [PAY_W-1:0]  res_pay_o,
  input logic              idle_o
);
  assert_hold_stable_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |=> res_valid_o && $stable(res_hit_o) &&
      $stable(res_key_o) && $stable(res_slot_o) && $stable(res_pay_o));

  assert_no_take_on_stall_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_ready_i |-> !key_ready_o);

  assert_miss_pay_zero_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && !res_hit_o |-> res_pay_o == '0);

  assert_hit_not_marker_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o && res_hit_o |-> res_key_o != {KEY_W{1'b1}});

  assert_idle_quiet_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_o && !key_valid_i |=> !res_valid_o);
endmodule

bind hash_probe_engine hash_probe_engine_chk #(
  .KEY_W(KEY_W), .PAY_W(PAY_W), .ADDR_W(ADDR_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .key_valid_i (key_valid_i),
  .key_ready_o (key_ready_o),
  .res_valid_o (res_valid_o),
  .res_ready_i (res_ready_i),
  .res_hit_o   (res_hit_o),
  .res_key_o   (res_key_o),
  .res_slot_o  (res_slot_o),
  .res_pay_o   (res_pay_o),
  .idle_o      (idle_o)
);

// File: tb/hash_probe_engine_test.sv
module hash_probe_engine_test;
  localparam int CLK_PERIOD = 10;
  localparam int KW = 8;
  localparam int PW = 8;
  localparam int AW = 4;
  localparam int NS = 1 << AW;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr_en_i = 1'b0;
  logic [AW-1:0] wr_addr_i = '0;
  logic [KW-1:0] wr_key_i = '0;
  logic [PW-1:0] wr_pay_i = '0;
  logic key_valid_i = 1'b0;
  logic [KW-1:0] key_i = '0;
  logic key_ready_o, res_valid_o, res_hit_o, idle_o;
  logic res_ready_i = 1'b1;
  logic [KW-1:0] res_key_o;
  logic [AW-1:0] res_slot_o;
  logic [PW-1:0] res_pay_o;

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_probe_engine #(.LANES(4), .KEY_W(KW), .PAY_W(PW), .ADDR_W(AW)) uut (
    .clk_i(clk), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_key_i(wr_key_i), .wr_pay_i(wr_pay_i),
    .key_valid_i(key_valid_i), .key_i(key_i), .key_ready_o(key_ready_o),
    .res_valid_o(res_valid_o), .res_ready_i(res_ready_i), .res_hit_o(res_hit_o),
    .res_key_o(res_key_o), .res_slot_o(res_slot_o), .res_pay_o(res_pay_o),
    .idle_o(idle_o)
  );

  int n_chk = 0;
  int n_fail = 0;
  logic [KW-1:0] mkey [NS];
  logic [PW-1:0] mpay [NS];
  logic [KW-1:0] tx_key [600];
  logic [KW-1:0] rx_ord [600];
  int acc_cyc [600];
  int tx_cnt [256];
  int rx_cnt [256];
  int rx_n;
  int ready_mode = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic logic [AW-1:0] home(input logic [KW-1:0] k);
    return k[3:0] ^ k[7:4];
  endfunction

  task automatic model_clear();
    for (int s = 0; s < NS; s++) begin
      mkey[s] = '1;
      mpay[s] = '0;
    end
  endtask

  task automatic model_put(input logic [KW-1:0] k, input logic [PW-1:0] p);
    logic [AW-1:0] s;
    s = home(k);
    while (mkey[s] != 8'hFF) s = s + 1'b1;
    mkey[s] = k;
    mpay[s] = p;
  endtask

  task automatic load_table();
    for (int s = 0; s < NS; s++) begin
      @(negedge clk);
      wr_en_i = 1'b1; wr_addr_i = AW'(s); wr_key_i = mkey[s]; wr_pay_i = mpay[s];
    end
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  // independent slot walk giving the expected result and the requirement it covers
  task automatic expect_of(input logic [KW-1:0] k, output bit hit,
                           output logic [AW-1:0] slot, output logic [PW-1:0] pay,
                           output string tag);
    logic [AW-1:0] h, s;
    bit done;
    h = home(k); done = 0; hit = 0; pay = '0;
    slot = h - 1'b1; tag = "R6";
    for (int i = 0; i < NS; i++) begin
      s = h + AW'(i);
      if (!done && mkey[s] == k) begin
        done = 1; hit = 1; slot = s; pay = mpay[s];
        tag = (s == h) ? "R2" : "R4";
      end else if (!done && mkey[s] == 8'hFF) begin
        done = 1; slot = s;
        tag = (s == h) ? "R3" : "R5";
      end
    end
  endtask

  task automatic run(input int n);
    int sent, guard;
    bit prev_stall, busy_checked;
    logic p_hit;
    logic [KW-1:0] p_key;
    logic [AW-1:0] p_slot;
    logic [PW-1:0] p_pay;
    bit e_hit;
    logic [AW-1:0] e_slot;
    logic [PW-1:0] e_pay;
    string tag;
    sent = 0; guard = 0; rx_n = 0; prev_stall = 0; busy_checked = 0;
    p_hit = 0; p_key = '0; p_slot = '0; p_pay = '0;
    for (int k = 0; k < 256; k++) begin tx_cnt[k] = 0; rx_cnt[k] = 0; end
    for (int i = 0; i < n; i++) tx_cnt[tx_key[i]]++;
    while ((sent < n || rx_n < n) && guard < 40000) begin
      @(negedge clk);
      guard++;
      case (ready_mode)
        1: res_ready_i = (guard % 3) != 1;
        2: res_ready_i = (guard % 5) < 2;
        default: res_ready_i = 1'b1;
      endcase
      key_valid_i = (sent < n);
      key_i = (sent < n) ? tx_key[sent] : '0;
      #1;
      if (!busy_checked && sent > rx_n) begin
        busy_checked = 1;
        chk(idle_o == 1'b0, "R10", "idle while key in flight", idle_o, 0);
      end
      if (prev_stall)
        chk(res_valid_o && res_hit_o == p_hit && res_key_o == p_key &&
            res_slot_o == p_slot && res_pay_o == p_pay,
            "R7", "stalled result changed", res_key_o, p_key);
      if (res_valid_o && !res_ready_i)
        chk(key_ready_o == 1'b0, "R9", "key taken during stall", key_ready_o, 0);
      if (res_valid_o && res_ready_i) begin
        expect_of(res_key_o, e_hit, e_slot, e_pay, tag);
        chk(res_hit_o == e_hit, tag, "hit flag", res_hit_o, e_hit);
        chk(res_slot_o == e_slot, tag, "slot", res_slot_o, e_slot);
        chk(res_pay_o == e_pay, tag, "payload", res_pay_o, e_pay);
        rx_cnt[res_key_o]++;
        rx_ord[rx_n] = res_key_o;
        rx_n++;
      end
      if (key_valid_i && key_ready_o) begin
        acc_cyc[sent] = guard;
        sent++;
      end
      prev_stall = res_valid_o && !res_ready_i;
      p_hit = res_hit_o; p_key = res_key_o; p_slot = res_slot_o; p_pay = res_pay_o;
    end
    chk(guard < 40000, "R7", "run did not complete", rx_n, n);
    @(negedge clk);
    key_valid_i = 1'b0;
    res_ready_i = 1'b1;
    #1;
    chk(idle_o == 1'b1, "R10", "idle after drain", idle_o, 1);
    for (int k = 0; k < 256; k++)
      if (tx_cnt[k] != 0)
        chk(rx_cnt[k] == tx_cnt[k], "R7", "results per key", rx_cnt[k], tx_cnt[k]);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    #1;
    chk(res_valid_o == 1'b0, "R1", "res_valid after reset", res_valid_o, 0);
    chk(idle_o == 1'b1, "R1", "idle after reset", idle_o, 1);
    chk(key_ready_o == 1'b1, "R1", "key_ready after reset", key_ready_o, 1);

    // empty table straight from reset: every key misses at its home slot
    model_clear();
    for (int k = 0; k < 255; k++) tx_key[k] = KW'(k);
    ready_mode = 0;
    run(255);

    // sparse table with a chain wrapping past the last slot
    model_clear();
    model_put(8'h0F, 8'h0F ^ 8'hA5); model_put(8'h1E, 8'h1E ^ 8'hA5);
    model_put(8'h2D, 8'h2D ^ 8'hA5); model_put(8'h3C, 8'h3C ^ 8'hA5);
    model_put(8'h11, 8'h11 ^ 8'hA5); model_put(8'h50, 8'h50 ^ 8'hA5);
    model_put(8'h67, 8'h67 ^ 8'hA5); model_put(8'h9A, 8'h9A ^ 8'hA5);
    model_put(8'hC4, 8'hC4 ^ 8'hA5); model_put(8'h24, 8'h24 ^ 8'hA5);
    load_table();
    ready_mode = 1;
    run(255);
    ready_mode = 2;
    run(255);

    // full table: misses walk every slot
    model_clear();
    for (int i = 0; i < 15; i++) model_put(KW'(i*17 + 1), KW'(i*17 + 4));
    model_put(8'h80, 8'h83);
    load_table();
    ready_mode = 0;
    run(255);

    // each slot holds the key whose home it is
    model_clear();
    for (int s = 0; s < NS; s++) model_put(KW'(s), PW'(8'h40 + s));
    load_table();
    ready_mode = 0;
    for (int i = 0; i < 12; i++) tx_key[i] = KW'((i * 5 + 3) % NS);
    run(12);
    chk(acc_cyc[11] - acc_cyc[0] == 11, "R9", "accept span for 12 keys",
        acc_cyc[11] - acc_cyc[0], 11);
    for (int i = 0; i < 12; i++)
      chk(rx_ord[i] == tx_key[i], "R8", "home-hit result order", rx_ord[i], tx_key[i]);

    tx_key[0] = 8'h10; tx_key[1] = 8'h01; tx_key[2] = 8'h02; tx_key[3] = 8'h03;
    run(4);
    chk(rx_ord[0] != 8'h10, "R8", "long search reported first", rx_ord[0], 8'h01);
    chk(rx_ord[3] == 8'h10, "R8", "long search reported last", rx_ord[3], 8'h10);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule